// File: doc/BRIEF.md
# Qualified Event Counter with Length Trigger and Threshold

This block counts events reported by several root ports of a PCIe-style root complex. Each cycle it can receive one event. An event carries the index of the port it came from, a 16-bit requester ID and a length value. Before an event can count, it must pass three tests. Its port must be enabled in a select mask. Its requester ID must match a programmed value, unless that filter is turned off. Its length must lie on the selected side of a threshold.

The counter does not count from the moment it is enabled. It waits until an event that passes the port and requester filters also has a length on the selected side of a trigger value. That event arms the monitor. The monitor then stays armed until it is disabled or reset. The arming event is itself tested against the threshold in the same cycle. The configuration inputs behave like register fields and are held stable by the surrounding logic. The count, the overflow flag and the armed state are readable at all times.

Top module: `rp_evt_counter`

## Requirements
- R1: After reset, `cnt_val` is 0, `cnt_ovf` is 0 and `monitor_armed` is 0.
- R2: In the first cycle in which `cfg_en` is 1 after being 0, the count, the overflow flag and the armed state are cleared. An event presented in that cycle is neither counted nor able to arm.
- R3: An event from port p can arm or count only when bit p of `cfg_port_mask` is 1.
- R4: When `cfg_rid_en` is 1, only events with `ev_rid` equal to `cfg_rid` can arm or count. When it is 0, every requester matches.
- R5: With `cfg_trig_mode` = 0, a filtered event arms the monitor when `ev_len` > `cfg_trig_len`. With mode 1, it arms when `ev_len` < `cfg_trig_len`. A length equal to `cfg_trig_len` never arms.
- R6: Once armed, the monitor stays armed while enabled, even for events that miss the trigger. Driving `cfg_en` to 0 disarms it at the next edge, and the count holds its value while disabled.
- R7: With `cfg_thr_mode` = 0, an armed, filtered event counts only when `ev_len` > `cfg_thr_len`. With mode 1, it counts only when `ev_len` < `cfg_thr_len`. A length equal to `cfg_thr_len` never counts.
- R8: The event that arms the monitor is counted in the same cycle if it meets the threshold.
- R9: While the monitor is not armed, no event is counted.
- R10: Each counted event adds exactly one, visible after the clock edge that samples it. A cycle with `ev_vld` = 0 adds nothing.
- R11: The count saturates at all ones instead of wrapping. `cnt_ovf` is set by the increment that reaches all ones. It stays set until the next re-enable (R2) or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en | input | 1 | Counter enable; a rising value restarts the measurement |
| cfg_port_mask | input | NUM_PORTS | One bit per root port allowed to contribute |
| cfg_rid_en | input | 1 | Turns on the requester ID filter |
| cfg_rid | input | 16 | Requester ID to match |
| cfg_trig_mode | input | 1 | Trigger direction: 0 above, 1 below |
| cfg_trig_len | input | LEN_W | Trigger length |
| cfg_thr_mode | input | 1 | Threshold direction: 0 above, 1 below |
| cfg_thr_len | input | LEN_W | Threshold length |
| ev_vld | input | 1 | An event is present this cycle |
| ev_port | input | clog2(NUM_PORTS) | Index of the reporting port |
| ev_rid | input | 16 | Requester ID of the event |
| ev_len | input | LEN_W | Length of the event |
| cnt_val | output | CNT_W | Saturating event count |
| cnt_ovf | output | 1 | Sticky saturation flag |
| monitor_armed | output | 1 | The trigger has fired since the last enable |

## Verification
Reset release passes through a two-stage synchronizer, so the bench keeps its first enable at least three cycles after `rst_n` rises. After that, every result depends on the event sampled at a single rising edge. The count, the overflow flag and the armed state all change at that edge, so each is due exactly one edge after the event is driven. The driver applies each stimulus on a falling edge and queues the values it predicts for the next rising edge. The monitor compares them 1 ns after that rising edge, so every check falls inside the one cycle in which its result is due.

// File: rtl/rp_evt_pkg.sv
package rp_evt_pkg;
  localparam int RID_W = 16;

  typedef enum logic {
    DIR_ABOVE = 1'b0,
    DIR_BELOW = 1'b1
  } cmp_dir_e;
endpackage

// File: rtl/rp_len_cmp.sv
module rp_len_cmp
  import rp_evt_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] lim_i,
  input  cmp_dir_e         dir_i,
  output logic             hit_o
);
  // Strict comparison in both directions: equality never hits.
  always_comb begin
    if (dir_i == DIR_BELOW) hit_o = (len_i < lim_i);
    else                    hit_o = (len_i > lim_i);
  end
endmodule

// File: rtl/rp_src_filter.sv
module rp_src_filter
  import rp_evt_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [NUM_PORTS-1:0] mask_i,
  input  logic                 rid_en_i,
  input  logic [RID_W-1:0]     rid_i,
  input  logic                 vld_i,
  input  logic [PIDX_W-1:0]    port_i,
  input  logic [RID_W-1:0]     ev_rid_i,
  output logic                 pass_o
);
  logic [NUM_PORTS-1:0] port_hit;
  logic                 rid_ok;

  // Decode the port index against the mask, one lane per port.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_hit[p] = mask_i[p] & (port_i == PIDX_W'(p));
  end

  always_comb begin
    rid_ok = ~rid_en_i | (ev_rid_i == rid_i);
    pass_o = vld_i & rid_ok & (|port_hit);
  end
endmodule

// File: rtl/rp_sat_counter.sv
module rp_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             cnt_ce;

  always_comb begin
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    cnt_ce = clr_i | (inc_i & (cnt_q != CNT_MAX));
    if (clr_i) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (inc_i && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_d == CNT_MAX) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/rp_evt_counter.sv
module rp_evt_counter
  import rp_evt_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int LEN_W     = 12,
  parameter int CNT_W     = 32,
  localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_en,
  input  logic [NUM_PORTS-1:0] cfg_port_mask,
  input  logic                 cfg_rid_en,
  input  logic [RID_W-1:0]     cfg_rid,
  input  logic                 cfg_trig_mode,
  input  logic [LEN_W-1:0]     cfg_trig_len,
  input  logic                 cfg_thr_mode,
  input  logic [LEN_W-1:0]     cfg_thr_len,
  input  logic                 ev_vld,
  input  logic [PIDX_W-1:0]    ev_port,
  input  logic [RID_W-1:0]     ev_rid,
  input  logic [LEN_W-1:0]     ev_len,
  output logic [CNT_W-1:0]     cnt_val,
  output logic                 cnt_ovf,
  output logic                 monitor_armed
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic en_q;
  logic armed_q, armed_d, armed_ce;
  logic start, run;
  logic src_pass, trig_hit, thr_hit, fire, cnt_inc;

  rp_src_filter #(.NUM_PORTS(NUM_PORTS)) u_filt (
    .mask_i   (cfg_port_mask),
    .rid_en_i (cfg_rid_en),
    .rid_i    (cfg_rid),
    .vld_i    (ev_vld),
    .port_i   (ev_port),
    .ev_rid_i (ev_rid),
    .pass_o   (src_pass)
  );

  rp_len_cmp #(.LEN_W(LEN_W)) u_trig_cmp (
    .len_i (ev_len),
    .lim_i (cfg_trig_len),
    .dir_i (cmp_dir_e'(cfg_trig_mode)),
    .hit_o (trig_hit)
  );

  rp_len_cmp #(.LEN_W(LEN_W)) u_thr_cmp (
    .len_i (ev_len),
    .lim_i (cfg_thr_len),
    .dir_i (cmp_dir_e'(cfg_thr_mode)),
    .hit_o (thr_hit)
  );

  always_comb begin
    start   = cfg_en & ~en_q;
    run     = cfg_en & en_q;
    fire    = run & src_pass & trig_hit;
    cnt_inc = run & src_pass & thr_hit & (armed_q | fire);
    armed_d  = armed_q;
    armed_ce = 1'b0;
    if (start || !cfg_en) begin
      armed_d  = 1'b0;
      armed_ce = armed_q;
    end else if (fire) begin
      armed_d  = 1'b1;
      armed_ce = ~armed_q;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      en_q <= cfg_en;
      if (armed_ce) armed_q <= armed_d;
    end
  end

  rp_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .clr_i  (start),
    .inc_i  (cnt_inc),
    .cnt_o  (cnt_val),
    .ovf_o  (cnt_ovf)
  );

  assign monitor_armed = armed_q;
endmodule

// File: rtl/rp_evt_counter_chk.sv
module rp_evt_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             en_q,
  input logic [CNT_W-1:0] cnt_val,
  input logic             cnt_ovf,
  input logic             monitor_armed
);
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !en_q) |=> (cnt_val == '0 && !cnt_ovf && !monitor_armed));

  p_arm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (monitor_armed && cfg_en && en_q) |=> monitor_armed);

  p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !monitor_armed);

  p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cnt_val));

  p_no_count_unarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!monitor_armed && cfg_en && en_q) |=> (monitor_armed || $stable(cnt_val)));

  p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_val) |-> (cnt_val == '0 || cnt_val == $past(cnt_val) + 1'b1));

  p_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cnt_val) && cfg_en && en_q) |=> (&cnt_val));

  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ovf && cfg_en && en_q) |=> cnt_ovf);

  p_ovf_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ovf |-> (&cnt_val));
endmodule

bind rp_evt_counter rp_evt_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_en        (cfg_en),
  .en_q          (en_q),
  .cnt_val       (cnt_val),
  .cnt_ovf       (cnt_ovf),
  .monitor_armed (monitor_armed)
);

// File: tb/tb_rp_evt_counter.sv
`timescale 1ns/1ps
module tb_rp_evt_counter;
  localparam int NP = 4;
  localparam int LW = 12;
  localparam int CW = 6;
  localparam logic [CW-1:0] MAXV = '1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_en, cfg_rid_en, cfg_trig_mode, cfg_thr_mode;
  logic [NP-1:0] cfg_port_mask;
  logic [15:0]   cfg_rid, ev_rid;
  logic [LW-1:0] cfg_trig_len, cfg_thr_len, ev_len;
  logic          ev_vld;
  logic [1:0]    ev_port;
  logic [CW-1:0] cnt_val;
  logic          cnt_ovf, monitor_armed;

  always #2 clk = ~clk;

  rp_evt_counter #(.NUM_PORTS(NP), .LEN_W(LW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_port_mask(cfg_port_mask),
    .cfg_rid_en(cfg_rid_en), .cfg_rid(cfg_rid), .cfg_trig_mode(cfg_trig_mode),
    .cfg_trig_len(cfg_trig_len), .cfg_thr_mode(cfg_thr_mode),
    .cfg_thr_len(cfg_thr_len), .ev_vld(ev_vld), .ev_port(ev_port),
    .ev_rid(ev_rid), .ev_len(ev_len), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
    .monitor_armed(monitor_armed)
  );

  typedef struct {
    logic [CW-1:0] cnt;
    logic          ovf;
    logic          armed;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;

  // Shadow configuration, copied to the DUT at each driving edge.
  logic          s_en = 1'b0, s_rid_en = 1'b0, s_tmode = 1'b0, s_hmode = 1'b0;
  logic [NP-1:0] s_mask = '0;
  logic [15:0]   s_rid = '0;
  logic [LW-1:0] s_tlen = '0, s_hlen = '0;

  // Reference model state.
  logic [CW-1:0] m_cnt = '0;
  logic          m_ovf = 1'b0, m_armed = 1'b0, m_enq = 1'b0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic vld, input logic [1:0] port, input logic [15:0] rid,
                      input logic [LW-1:0] len, input string tag);
    logic start, run, qual, trig, thr, fire, inc;
    exp_t e;
    @(negedge clk);
    cfg_en = s_en; cfg_port_mask = s_mask; cfg_rid_en = s_rid_en; cfg_rid = s_rid;
    cfg_trig_mode = s_tmode; cfg_trig_len = s_tlen;
    cfg_thr_mode = s_hmode; cfg_thr_len = s_hlen;
    ev_vld = vld; ev_port = port; ev_rid = rid; ev_len = len;
    start = s_en & ~m_enq;
    run   = s_en & m_enq;
    qual  = vld & s_mask[port] & (~s_rid_en | (rid == s_rid));
    trig  = s_tmode ? (len < s_tlen) : (len > s_tlen);
    thr   = s_hmode ? (len < s_hlen) : (len > s_hlen);
    fire  = run & qual & trig;
    inc   = run & qual & thr & (m_armed | fire);
    if (start) begin
      m_cnt = '0; m_ovf = 1'b0; m_armed = 1'b0;
    end else begin
      if (!s_en) m_armed = 1'b0;
      else if (fire) m_armed = 1'b1;
      if (inc && m_cnt != MAXV) begin
        m_cnt = m_cnt + 1'b1;
        if (m_cnt == MAXV) m_ovf = 1'b1;
      end
    end
    m_enq = s_en;
    e.cnt = m_cnt; e.ovf = m_ovf; e.armed = m_armed; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 2'd0, 16'h0, '0, tag);
  endtask

  // Monitor: compare after the rising edge that follows each driven stimulus.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, "count", int'(cnt_val), int'(e.cnt));
      check(e.tag, "ovf", int'(cnt_ovf), int'(e.ovf));
      check(e.tag, "armed", int'(monitor_armed), int'(e.armed));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_en = 1'b0; cfg_port_mask = '0; cfg_rid_en = 1'b0; cfg_rid = '0;
    cfg_trig_mode = 1'b0; cfg_trig_len = '0; cfg_thr_mode = 1'b0; cfg_thr_len = '0;
    ev_vld = 1'b0; ev_port = '0; ev_rid = '0; ev_len = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", "count", int'(cnt_val), 0);
    check("R1", "ovf", int'(cnt_ovf), 0);
    check("R1", "armed", int'(monitor_armed), 0);
    rst_n = 1'b1;
    repeat (3) idle("R1");

    s_mask = 4'b0101; s_tmode = 1'b0; s_tlen = 12'd100; s_hmode = 1'b0; s_hlen = 12'd50;
    s_en = 1'b1;
    step(1'b1, 2'd0, 16'h0, 12'd200, "R2");   // enable edge: event ignored
    step(1'b1, 2'd0, 16'h0, 12'd80,  "R9");   // below trigger, not armed
    step(1'b1, 2'd0, 16'h0, 12'd100, "R5");   // equal to trigger
    step(1'b1, 2'd1, 16'h0, 12'd200, "R3");   // masked port
    step(1'b1, 2'd2, 16'h0, 12'd150, "R8");   // arms and counts
    step(1'b1, 2'd0, 16'h0, 12'd50,  "R7");   // equal to threshold
    step(1'b1, 2'd0, 16'h0, 12'd60,  "R7");
    step(1'b1, 2'd0, 16'h0, 12'd40,  "R7");
    step(1'b0, 2'd0, 16'h0, 12'd90,  "R10");  // no valid
    s_rid_en = 1'b1; s_rid = 16'h0108;
    step(1'b1, 2'd2, 16'h0100, 12'd60, "R4");
    step(1'b1, 2'd2, 16'h0108, 12'd60, "R4");
    s_hmode = 1'b1; s_hlen = 12'd30;
    step(1'b1, 2'd0, 16'h0108, 12'd20, "R7");
    step(1'b1, 2'd0, 16'h0108, 12'd30, "R7");
    step(1'b1, 2'd0, 16'h0108, 12'd40, "R7");
    s_en = 1'b0;
    step(1'b1, 2'd0, 16'h0108, 12'd20, "R6"); // disabled: disarm, hold
    idle("R6");
    s_rid_en = 1'b0; s_tmode = 1'b1; s_tlen = 12'd10;
    s_en = 1'b1;
    idle("R2");
    step(1'b1, 2'd2, 16'h0777, 12'd10, "R5"); // equal, mode 1
    step(1'b1, 2'd2, 16'h0777, 12'd5,  "R8"); // arms below, counts
    step(1'b1, 2'd2, 16'h0777, 12'd20, "R6"); // misses trigger, still counts
    for (int i = 0; i < 70; i++) step(1'b1, 2'd0, 16'h0, 12'd20, "R11");
    idle("R11");
    s_en = 1'b0; idle("R6");
    s_en = 1'b1; idle("R2");                   // re-enable clears ovf
    step(1'b1, 2'd0, 16'h0, 12'd1, "R2");
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule